// File: doc/BRIEF.md
# Lane Fetch Command Manager

This unit sits in one lane of a vector-thread machine and decides which instruction-block fetch the lane works on next. Two sources feed it. The scalar control processor pushes fetch commands into a small command queue, either a broadcast that targets every virtual processor (VP) of the lane or a fetch aimed at one VP. The lane's own VPs report when they finish a block and may, under a predicate, ask for a follow-on block, which is parked in a per-VP pending-address slot.

For the chosen fetch, the block address is compared against an eight-entry, fully associative tag store that mirrors the lane's block cache. On a miss, the unit raises a fill request carrying the address and the cache slot to overwrite, then waits for the fill acknowledge and looks up again. On a hit it presents an execute directive naming the cache slot, the VP and whether the block applies to all VPs. A VP counts as busy from the moment a fetch for it is accepted until it reports its block done with no follow-on fetch. Control commands aimed at a busy VP, or broadcasts while any VP is busy, stay in the queue, and the queue head blocks the entries behind it.

Top module: `lane_fetch_cmu`

## Requirements
- R1: After reset, `dir_valid` and `fill_valid` are low and `cp_ready` is high.
- R2: A fetch whose address is absent from the tag store raises `fill_valid` with `fill_addr` equal to the block address and `fill_idx` equal to the replacement slot, holding both until `fill_ack`; the directive that follows names that slot.
- R3: A fetch whose address is present issues a directive with `dir_idx` equal to the matching slot and raises no fill request.
- R4: A directive carries `dir_bcast`=1 and `dir_vp`=0 for a broadcast command (`cp_bcast`=1), and `dir_bcast`=0 with `dir_vp` equal to the target for a single-VP or self-issued fetch; it holds stable while `dir_ready` is low.
- R5: When a VP has a pending self-issued fetch, that fetch is served before any queued control command.
- R6: Among VPs with pending self-issued fetches, service is round-robin: the search starts at the VP after the one last served and wraps.
- R7: A block-done report with `ex_next`=0 records no fetch; that VP becomes idle and no directive follows on its behalf.
- R8: A queued control command waits while its target VP is busy (a broadcast waits while any VP is busy), and commands leave the queue strictly in arrival order.
- R9: Replacement is round-robin over the eight tag slots in fill order, so the ninth distinct block evicts slot 0 and a later fetch of the evicted address misses again.
- R10: `cp_ready` drops once the command queue holds its full depth (4 entries) and a command offered then is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cp_valid | input | 1 | Control processor offers a fetch command |
| cp_ready | output | 1 | Command queue has room |
| cp_bcast | input | 1 | 1: broadcast to all VPs, 0: fetch for `cp_vp` |
| cp_vp | input | 3 | Target VP of a single-VP fetch |
| cp_addr | input | 16 | Block address of the command |
| ex_done | input | 1 | A VP finished its current block |
| ex_vp | input | 3 | VP that finished |
| ex_next | input | 1 | Predicate: the VP requests a follow-on block |
| ex_next_addr | input | 16 | Address of the follow-on block |
| fill_valid | output | 1 | Fill request to the fill unit |
| fill_addr | output | 16 | Block address to fill |
| fill_idx | output | 3 | Cache slot the fill overwrites |
| fill_ack | input | 1 | Fill complete |
| dir_valid | output | 1 | Execute directive valid |
| dir_ready | input | 1 | Execution queue accepts the directive |
| dir_idx | output | 3 | Block cache slot to execute |
| dir_vp | output | 3 | VP to run the block |
| dir_bcast | output | 1 | Block runs for every VP of the lane |

## Verification
The main flow is driven with a broadcast miss, a burst of block-done reports where three VPs request follow-on blocks in a non-ascending arrival order while the unit is stalled in a fill, and a control command queued behind them; the directive order separates round-robin from fixed-priority selection and shows thread fetches overtaking the queue. Single-VP commands aimed at busy VPs, with an idle-VP command behind them, tell head-of-line ordering apart from out-of-order issue, and a broadcast behind one busy VP checks the all-idle condition. A run of distinct addresses past the tag capacity, followed by a return to an evicted address, distinguishes round-robin replacement from any reuse of stale tags, while a full queue probes back-pressure.

// File: rtl/lfc_pkg.sv
package lfc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOOK  = 2'd1,
    ST_FILL  = 2'd2,
    ST_ISSUE = 2'd3
  } lfc_state_e;
endpackage

// File: rtl/lfc_cmd_fifo.sv
module lfc_cmd_fifo #(
  parameter int W     = 20,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end

  // R10: an offer refused while full leaves the occupancy untouched
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop) |=> (cnt == CW'(DEPTH)));
endmodule

// File: rtl/lfc_thread_table.sv
module lfc_thread_table #(
  parameter int NVP = 8,
  parameter int AW  = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   set_en,
  input  logic [$clog2(NVP)-1:0] set_vp,
  input  logic [AW-1:0]          set_addr,
  input  logic                   take,
  output logic                   any,
  output logic [$clog2(NVP)-1:0] pick_vp,
  output logic [AW-1:0]          pick_addr,
  output logic [NVP-1:0]         pend
);
  localparam int VPW = $clog2(NVP);

  logic [AW-1:0]  addr_mem [NVP];
  logic [VPW-1:0] rr;

  always_ff @(posedge clk) begin
    if (set_en) addr_mem[set_vp] <= set_addr;
  end

  always_comb begin
    any     = 1'b0;
    pick_vp = '0;
    for (int off = NVP - 1; off >= 0; off--) begin
      int unsigned j;
      j = (int'(rr) + off) % NVP;
      if (pend[j]) begin
        any     = 1'b1;
        pick_vp = VPW'(j);
      end
    end
  end

  assign pick_addr = addr_mem[pick_vp];

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
      rr   <= '0;
    end else begin
      if (take && any) begin
        pend[pick_vp] <= 1'b0;
        rr <= (pick_vp == VPW'(NVP - 1)) ? '0 : pick_vp + 1'b1;
      end
      if (set_en) pend[set_vp] <= 1'b1;
    end
  end

  // R6: a served VP loses its pending request on the next cycle
  a_r6_served_cleared: assert property (@(posedge clk) disable iff (rst)
    (take && any && !(set_en && set_vp == pick_vp)) |=> !pend[$past(pick_vp)]);
endmodule

// File: rtl/lfc_tag_store.sv
module lfc_tag_store #(
  parameter int NTAG = 8,
  parameter int AW   = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [AW-1:0]           look_addr,
  output logic                    hit,
  output logic [$clog2(NTAG)-1:0] hit_idx,
  output logic [$clog2(NTAG)-1:0] victim,
  input  logic                    ins_en,
  input  logic [$clog2(NTAG)-1:0] ins_idx,
  input  logic [AW-1:0]           ins_addr
);
  localparam int TIW = $clog2(NTAG);

  logic [AW-1:0]   tag_q [NTAG];
  logic [NTAG-1:0] vld_q;
  logic [NTAG-1:0] match;
  logic [TIW-1:0]  rr;

  for (genvar g = 0; g < NTAG; g++) begin : g_cmp
    assign match[g] = vld_q[g] && (tag_q[g] == look_addr);
  end

  assign hit    = |match;
  assign victim = rr;

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < NTAG; i++) begin
      if (match[i]) hit_idx = TIW'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (ins_en) tag_q[ins_idx] <= ins_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      rr    <= '0;
    end else if (ins_en) begin
      vld_q[ins_idx] <= 1'b1;
      rr <= (rr == TIW'(NTAG - 1)) ? '0 : rr + 1'b1;
    end
  end

  // R9: a block address never sits in two slots at once
  a_r9_single_match: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match));
endmodule

// File: rtl/lane_fetch_cmu.sv
module lane_fetch_cmu
  import lfc_pkg::*;
#(
  parameter int NVP    = 8,
  parameter int AW     = 16,
  parameter int NTAG   = 8,
  parameter int QDEPTH = 4,
  localparam int VPW   = $clog2(NVP),
  localparam int TIW   = $clog2(NTAG)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cp_valid,
  output logic           cp_ready,
  input  logic           cp_bcast,
  input  logic [VPW-1:0] cp_vp,
  input  logic [AW-1:0]  cp_addr,
  input  logic           ex_done,
  input  logic [VPW-1:0] ex_vp,
  input  logic           ex_next,
  input  logic [AW-1:0]  ex_next_addr,
  output logic           fill_valid,
  output logic [AW-1:0]  fill_addr,
  output logic [TIW-1:0] fill_idx,
  input  logic           fill_ack,
  output logic           dir_valid,
  input  logic           dir_ready,
  output logic [TIW-1:0] dir_idx,
  output logic [VPW-1:0] dir_vp,
  output logic           dir_bcast
);
  localparam int CMDW = 1 + VPW + AW;

  lfc_state_e     st;
  logic [AW-1:0]  cur_addr;
  logic [VPW-1:0] cur_vp;
  logic           cur_bcast;
  logic [NVP-1:0] running, run_nxt, active;

  // command queue
  logic [CMDW-1:0] q_head;
  logic            q_full, q_empty;
  logic            h_bcast;
  logic [VPW-1:0]  h_vp;
  logic [AW-1:0]   h_addr;

  lfc_cmd_fifo #(.W(CMDW), .DEPTH(QDEPTH)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .push  (cp_valid),
    .wdata ({cp_bcast, cp_vp, cp_addr}),
    .pop   (sel_cp),
    .head  (q_head),
    .full  (q_full),
    .empty (q_empty)
  );

  assign cp_ready = !q_full;
  assign {h_bcast, h_vp, h_addr} = q_head;

  // pending self-issued fetches
  logic           thr_any;
  logic [VPW-1:0] thr_vp;
  logic [AW-1:0]  thr_addr;
  logic [NVP-1:0] thr_pend;
  logic           sel_thr, sel_cp, head_ok;

  lfc_thread_table #(.NVP(NVP), .AW(AW)) u_thr (
    .clk       (clk),
    .rst       (rst),
    .set_en    (ex_done && ex_next),
    .set_vp    (ex_vp),
    .set_addr  (ex_next_addr),
    .take      (sel_thr),
    .any       (thr_any),
    .pick_vp   (thr_vp),
    .pick_addr (thr_addr),
    .pend      (thr_pend)
  );

  // tag store
  logic           t_hit;
  logic [TIW-1:0] t_hit_idx, t_victim;
  logic           ins_en;

  assign ins_en = (st == ST_FILL) && fill_ack;

  lfc_tag_store #(.NTAG(NTAG), .AW(AW)) u_tags (
    .clk       (clk),
    .rst       (rst),
    .look_addr (cur_addr),
    .hit       (t_hit),
    .hit_idx   (t_hit_idx),
    .victim    (t_victim),
    .ins_en    (ins_en),
    .ins_idx   (fill_idx),
    .ins_addr  (cur_addr)
  );

  // arbitration: thread fetches first, then the queue head if its VPs are idle
  assign active  = running | thr_pend;
  assign head_ok = !q_empty && (h_bcast ? (active == '0) : !active[h_vp]);
  assign sel_thr = (st == ST_IDLE) && thr_any;
  assign sel_cp  = (st == ST_IDLE) && !thr_any && head_ok;

  always_comb begin
    run_nxt = running;
    if (ex_done) run_nxt[ex_vp] = 1'b0;
    if (sel_thr) run_nxt[thr_vp] = 1'b1;
    if (sel_cp) begin
      if (h_bcast) run_nxt = '1;
      else         run_nxt[h_vp] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) running <= '0;
    else     running <= run_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      cur_addr   <= '0;
      cur_vp     <= '0;
      cur_bcast  <= 1'b0;
      fill_valid <= 1'b0;
      fill_addr  <= '0;
      fill_idx   <= '0;
      dir_valid  <= 1'b0;
      dir_idx    <= '0;
      dir_vp     <= '0;
      dir_bcast  <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (sel_thr) begin
            cur_addr  <= thr_addr;
            cur_vp    <= thr_vp;
            cur_bcast <= 1'b0;
            st        <= ST_LOOK;
          end else if (sel_cp) begin
            cur_addr  <= h_addr;
            cur_vp    <= h_bcast ? '0 : h_vp;
            cur_bcast <= h_bcast;
            st        <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          if (t_hit) begin
            dir_valid <= 1'b1;
            dir_idx   <= t_hit_idx;
            dir_vp    <= cur_vp;
            dir_bcast <= cur_bcast;
            st        <= ST_ISSUE;
          end else begin
            fill_valid <= 1'b1;
            fill_addr  <= cur_addr;
            fill_idx   <= t_victim;
            st         <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (fill_ack) begin
            fill_valid <= 1'b0;
            st         <= ST_LOOK;
          end
        end
        ST_ISSUE: begin
          if (dir_ready) begin
            dir_valid <= 1'b0;
            st        <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R2: fill request holds its address and slot until acknowledged
  a_r2_fill_hold: assert property (@(posedge clk) disable iff (rst)
    (fill_valid && !fill_ack) |=> (fill_valid && $stable(fill_addr) && $stable(fill_idx)));

  // R4: directive fields hold while the execution queue stalls
  a_r4_dir_hold: assert property (@(posedge clk) disable iff (rst)
    (dir_valid && !dir_ready) |=> (dir_valid && $stable(dir_idx) && $stable(dir_vp) && $stable(dir_bcast)));

  // R3: never a fill request and a directive at once
  a_r3_one_request: assert property (@(posedge clk) disable iff (rst)
    !(fill_valid && dir_valid));

  // R8: a VP holding a pending fetch is never also running
  a_r8_pending_idle: assert property (@(posedge clk) disable iff (rst)
    sel_thr |-> !running[thr_vp]);
endmodule

// File: tb/lane_fetch_cmu_test.sv
module lane_fetch_cmu_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cp_valid = 1'b0, cp_bcast = 1'b0;
  logic [2:0]  cp_vp = '0;
  logic [15:0] cp_addr = '0;
  logic        cp_ready;
  logic        ex_done = 1'b0, ex_next = 1'b0;
  logic [2:0]  ex_vp = '0;
  logic [15:0] ex_next_addr = '0;
  logic        fill_valid, fill_ack = 1'b0;
  logic [15:0] fill_addr;
  logic [2:0]  fill_idx;
  logic        dir_valid, dir_ready = 1'b1, dir_bcast;
  logic [2:0]  dir_idx, dir_vp;

  int total = 0, bad = 0, dir_cnt = 0, fill_cnt = 0, fill_exp = 0;
  bit done_flag = 0;

  int    e_idx[$], e_vp[$], e_bc[$];
  string e_req[$];
  int    f_addr[$], f_idx[$];

  int m_tag[8];
  bit m_vld[8];
  int m_rr = 0;

  always #4 clk = ~clk;

  lane_fetch_cmu uut (
    .clk(clk), .rst(rst),
    .cp_valid(cp_valid), .cp_ready(cp_ready), .cp_bcast(cp_bcast),
    .cp_vp(cp_vp), .cp_addr(cp_addr),
    .ex_done(ex_done), .ex_vp(ex_vp), .ex_next(ex_next), .ex_next_addr(ex_next_addr),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_idx(fill_idx), .fill_ack(fill_ack),
    .dir_valid(dir_valid), .dir_ready(dir_ready), .dir_idx(dir_idx),
    .dir_vp(dir_vp), .dir_bcast(dir_bcast)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // model of the tag store: round-robin fill order
  task automatic exp_dir(input int vp, input int bc, input int addr, input string req);
    int idx;
    idx = -1;
    for (int i = 0; i < 8; i++) if (m_vld[i] && m_tag[i] == addr) idx = i;
    if (idx < 0) begin
      idx = m_rr;
      m_tag[m_rr] = addr;
      m_vld[m_rr] = 1'b1;
      m_rr = (m_rr + 1) % 8;
      f_addr.push_back(addr);
      f_idx.push_back(idx);
      fill_exp++;
    end
    e_idx.push_back(idx);
    e_vp.push_back(vp);
    e_bc.push_back(bc);
    e_req.push_back(req);
  endtask

  task automatic cp_push(input bit bc, input int vp, input int addr);
    @(negedge clk);
    while (!cp_ready) @(negedge clk);
    cp_valid = 1'b1;
    cp_bcast = bc;
    cp_vp    = 3'(vp);
    cp_addr  = 16'(addr);
    @(negedge clk);
    cp_valid = 1'b0;
  endtask

  task automatic vp_done(input int vp, input bit nxt, input int addr);
    @(negedge clk);
    ex_done      = 1'b1;
    ex_vp        = 3'(vp);
    ex_next      = nxt;
    ex_next_addr = 16'(addr);
    @(negedge clk);
    ex_done = 1'b0;
    ex_next = 1'b0;
  endtask

  task automatic drain();
    while (e_vp.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  // scoreboard monitor for directives
  always @(negedge clk) begin
    if (!rst && dir_valid && dir_ready) begin
      dir_cnt++;
      if (e_vp.size() == 0) begin
        check(1'b0, "R4 unexpected directive", int'(dir_vp), -1);
      end else begin
        int ei, ev, eb;
        string er;
        ei = e_idx.pop_front();
        ev = e_vp.pop_front();
        eb = e_bc.pop_front();
        er = e_req.pop_front();
        check(int'(dir_idx) == ei, {er, " dir_idx"}, int'(dir_idx), ei);
        check(int'(dir_vp) == ev && int'(dir_bcast) == eb, {er, " R4 dir_vp*2+bcast"},
              int'(dir_vp) * 2 + int'(dir_bcast), ev * 2 + eb);
      end
    end
  end

  // fill responder: compares then acknowledges after a delay
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && fill_valid) begin
        fill_cnt++;
        if (f_addr.size() == 0) begin
          check(1'b0, "R3 unexpected fill", int'(fill_addr), -1);
        end else begin
          int fa, fi;
          fa = f_addr.pop_front();
          fi = f_idx.pop_front();
          check(int'(fill_addr) == fa, "R2 fill_addr", int'(fill_addr), fa);
          check(int'(fill_idx) == fi, "R2 fill_idx", int'(fill_idx), fi);
        end
        repeat (10) @(negedge clk);
        fill_ack = 1'b1;
        @(negedge clk);
        fill_ack = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int c0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(!dir_valid, "R1 dir_valid", int'(dir_valid), 0);
    check(!fill_valid, "R1 fill_valid", int'(fill_valid), 0);
    check(cp_ready, "R1 cp_ready", int'(cp_ready), 1);

    // R2 R4: broadcast miss
    exp_dir(0, 1, 'h100, "R2");
    cp_push(1'b1, 0, 'h100);
    drain();

    // R5 R6: follow-on fetches arrive while the unit waits in a fill
    exp_dir(3, 0, 'h200, "R6");
    exp_dir(5, 0, 'h300, "R6");
    exp_dir(6, 0, 'h100, "R3");
    exp_dir(1, 0, 'h100, "R6");
    exp_dir(0, 0, 'h100, "R5");
    vp_done(3, 1'b1, 'h200);
    vp_done(0, 1'b0, 0);
    vp_done(2, 1'b0, 0);
    vp_done(4, 1'b0, 0);
    vp_done(5, 1'b1, 'h300);
    vp_done(6, 1'b1, 'h100);
    vp_done(7, 1'b0, 0);
    vp_done(1, 1'b1, 'h100);
    cp_push(1'b0, 0, 'h100);
    drain();

    // R7: predicate-false completions end the threads
    vp_done(3, 1'b0, 0);
    vp_done(5, 1'b0, 0);
    vp_done(6, 1'b0, 0);
    vp_done(1, 1'b0, 0);
    vp_done(0, 1'b0, 0);
    c0 = dir_cnt;
    repeat (20) @(negedge clk);
    check(dir_cnt == c0, "R7 no directive after false predicate", dir_cnt, c0);
    exp_dir(6, 0, 'h300, "R7");
    cp_push(1'b0, 6, 'h300);
    drain();
    vp_done(6, 1'b0, 0);

    // R8: head blocked by a busy VP, later command waits behind it
    exp_dir(0, 0, 'h100, "R8");
    cp_push(1'b0, 0, 'h100);
    drain();
    cp_push(1'b0, 0, 'h200);
    cp_push(1'b0, 2, 'h300);
    c0 = dir_cnt;
    repeat (20) @(negedge clk);
    check(dir_cnt == c0, "R8 held while VP busy", dir_cnt, c0);
    exp_dir(0, 0, 'h200, "R8");
    exp_dir(2, 0, 'h300, "R8");
    vp_done(0, 1'b0, 0);
    drain();
    vp_done(0, 1'b0, 0);
    vp_done(2, 1'b0, 0);

    // R8: broadcast waits for every VP to be idle
    exp_dir(4, 0, 'h100, "R8");
    cp_push(1'b0, 4, 'h100);
    drain();
    cp_push(1'b1, 0, 'h200);
    c0 = dir_cnt;
    repeat (20) @(negedge clk);
    check(dir_cnt == c0, "R8 broadcast held", dir_cnt, c0);
    exp_dir(0, 1, 'h200, "R8");
    vp_done(4, 1'b0, 0);
    drain();
    for (int v = 0; v < 8; v++) vp_done(v, 1'b0, 0);

    // R10: queue full while its head is blocked
    exp_dir(0, 0, 'h100, "R10");
    cp_push(1'b0, 0, 'h100);
    drain();
    for (int k = 0; k < 4; k++) cp_push(1'b0, 0, 'h300);
    @(negedge clk);
    check(!cp_ready, "R10 cp_ready when full", int'(cp_ready), 0);
    for (int k = 0; k < 4; k++) begin
      exp_dir(0, 0, 'h300, "R10");
      vp_done(0, 1'b0, 0);
      drain();
    end
    vp_done(0, 1'b0, 0);
    check(cp_ready, "R10 cp_ready after drain", int'(cp_ready), 1);

    // R9: round-robin replacement past eight distinct blocks
    for (int a = 4; a <= 9; a++) begin
      exp_dir(1, 0, a * 'h100, "R9");
      cp_push(1'b0, 1, a * 'h100);
      drain();
      vp_done(1, 1'b0, 0);
    end
    exp_dir(1, 0, 'h100, "R9");
    cp_push(1'b0, 1, 'h100);
    drain();
    vp_done(1, 1'b0, 0);
    exp_dir(1, 0, 'h300, "R9");
    cp_push(1'b0, 1, 'h300);
    drain();
    vp_done(1, 1'b0, 0);

    repeat (5) @(negedge clk);
    check(fill_cnt == fill_exp, "R2 fill count", fill_cnt, fill_exp);
    check(e_vp.size() == 0, "R4 directives outstanding", e_vp.size(), 0);

    done_flag = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule